// File: doc/BRIEF.md
# Tagged Sample FIFO with Threshold Flag

This block buffers 32-bit sample words. Each word already carries its channel tag. The converter side pushes words with a write strobe, and the bus-side reader pops them with a read strobe. The block reports how many words it holds.

It raises a level flag while that number is strictly above a programmable threshold. With a zero threshold, the flag falling marks the moment the buffer has drained, and the block emits a one-cycle drained event at that point.

Misuse is recorded in sticky flags that only software clears:
- pushing into a full buffer sets the overflow flag;
- popping from an empty buffer sets the underflow flag.

Software may also block new input without losing what is stored. It can request a clear, which empties the buffer and then holds it in a flush state for a fixed number of cycles before the request bit drops by itself.

Top module: `tsf_fifo_top`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, all flags and `clr_busy` are 0, `rd_data` is 0, and `thr_q` holds the all-ones value with bit 0 cleared (0xE for the default 4-bit threshold, 0x3FFFE at full size).
- R2: Words leave in the order they entered. `rd_data` shows the popped word after the clock edge that accepts the read.
- R3: `level` counts the stored words, from 0 to DEPTH. A read and a write in the same cycle on a buffer that is neither empty nor full leave `level` unchanged.
- R4: `thr_flag` is 1 exactly while `level` is strictly greater than `thr_q`. `thr_we` loads `thr_wdata` into `thr_q` at the clock edge.
- R5: While `thr_q` is 0, the cycle in which `thr_flag` has just fallen shows `empty_evt` high for exactly one cycle.
- R6: A write accepted while `full` is 1 is dropped: pointers, `level` and contents are unchanged, and `ovf_flag` is set.
- R7: A read while `empty` is 1 leaves `rd_data` and `level` unchanged and sets `unf_flag`.
- R8: `ovf_flag` and `unf_flag` stay set until a pulse on `ovf_clr` or `unf_clr` respectively, or until reset. A new event in the same cycle as the clear pulse wins.
- R9: A pulse on `clr_req` empties the buffer at the next edge. `clr_busy` then stays 1 for FLUSH_CYC cycles and returns to 0 by itself. While the flush runs, reads and writes have no effect and set no flag.
- R10: While `in_dis` is 1, writes are dropped without setting `ovf_flag`, and stored words remain readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Tagged sample word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Last popped word |
| in_dis | input | 1 | Block new input |
| clr_req | input | 1 | Clear request pulse |
| clr_busy | output | 1 | Clear/flush in progress, self-clearing |
| thr_we | input | 1 | Threshold load strobe |
| thr_wdata | input | ADDR_W | New threshold value |
| thr_q | output | ADDR_W | Current threshold |
| ovf_clr | input | 1 | Clear sticky overflow |
| unf_clr | input | 1 | Clear sticky underflow |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| level | output | ADDR_W+1 | Number of stored words |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level equals DEPTH |
| thr_flag | output | 1 | Level above threshold |
| empty_evt | output | 1 | Drained event pulse (zero threshold) |

## Verification
The hardest condition to reach is the drained event. The threshold must first be lowered from its near-maximum reset value to zero, and then the last stored word must be popped. The bench does this with one write followed by one read, and checks `empty_evt` both in the cycle after the read and in the cycle after that.

The overflow case also takes deliberate set-up. The buffer is first filled to exactly DEPTH. An extra word is then pushed, after which every stored word is read back to show that the extra word never entered.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [0:0] {
        FL_IDLE = 1'b0,
        FL_HOLD = 1'b1
    } flush_state_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } tsf_events_t;

endpackage

// File: rtl/tsf_flush_timer.sv
module tsf_flush_timer #(
    parameter int FLUSH_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_req,
    output logic busy
);
    import tsf_pkg::*;

    localparam int FW = $clog2(FLUSH_CYC + 1);

    flush_state_e state_q;
    logic [FW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FL_IDLE;
            cnt_q   <= '0;
        end else if (clr_req) begin
            state_q <= FL_HOLD;
            cnt_q   <= FW'(FLUSH_CYC - 1);
        end else if (state_q == FL_HOLD) begin
            if (cnt_q == '0) begin
                state_q <= FL_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = (state_q == FL_HOLD);
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_dis,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   level,
    output logic              empty,
    output logic              full,
    output tsf_pkg::tsf_events_t ev
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr_q, rptr_q;
    logic [CW-1:0]     cnt_q;
    logic              wr_try, rd_try, wr_ok, rd_ok;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign wr_try = wr_en & ~in_dis & ~flush;
    assign rd_try = rd_en & ~flush;
    assign wr_ok  = wr_try & ~full;
    assign rd_ok  = rd_try & ~empty;

    assign ev.ovf = wr_try & full;
    assign ev.unf = rd_try & empty;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= mem[rptr_q];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) wptr_q <= wptr_q + 1'b1;
            if (rd_ok) rptr_q <= rptr_q + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign level = cnt_q;
endmodule

// File: rtl/tsf_thresh.sv
module tsf_thresh #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_we,
    input  logic [ADDR_W-1:0] thr_wdata,
    input  logic [ADDR_W:0]   level,
    output logic [ADDR_W-1:0] thr_q,
    output logic              thr_flag,
    output logic              empty_evt
);
    localparam logic [ADDR_W-1:0] THR_RST = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic flag_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q    <= THR_RST;
            flag_d_q <= 1'b0;
        end else begin
            if (thr_we) thr_q <= thr_wdata;
            flag_d_q <= thr_flag;
        end
    end

    assign thr_flag  = (level > {1'b0, thr_q});
    assign empty_evt = flag_d_q & ~thr_flag & (thr_q == '0);
endmodule

// File: rtl/tsf_fifo_top.sv
module tsf_fifo_top #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int FLUSH_CYC = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              in_dis,
    input  logic              clr_req,
    output logic              clr_busy,
    input  logic              thr_we,
    input  logic [ADDR_W-1:0] thr_wdata,
    output logic [ADDR_W-1:0] thr_q,
    input  logic              ovf_clr,
    input  logic              unf_clr,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic [ADDR_W:0]   level,
    output logic              empty,
    output logic              full,
    output logic              thr_flag,
    output logic              empty_evt
);
    import tsf_pkg::*;

    tsf_events_t ev;
    tsf_events_t sticky_q;
    logic        flush;

    tsf_flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk     (clk),
        .rst     (rst),
        .clr_req (clr_req),
        .busy    (clr_busy)
    );

    assign flush = clr_req | clr_busy;

    tsf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .in_dis  (in_dis),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .level   (level),
        .empty   (empty),
        .full    (full),
        .ev      (ev)
    );

    tsf_thresh #(.ADDR_W(ADDR_W)) u_thresh (
        .clk       (clk),
        .rst       (rst),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .level     (level),
        .thr_q     (thr_q),
        .thr_flag  (thr_flag),
        .empty_evt (empty_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
        end else begin
            if (ev.ovf)       sticky_q.ovf <= 1'b1;
            else if (ovf_clr) sticky_q.ovf <= 1'b0;
            if (ev.unf)       sticky_q.unf <= 1'b1;
            else if (unf_clr) sticky_q.unf <= 1'b0;
        end
    end

    assign ovf_flag = sticky_q.ovf;
    assign unf_flag = sticky_q.unf;
endmodule

// File: rtl/tsf_fifo_chk.sv
module tsf_fifo_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              in_dis,
    input logic              clr_req,
    input logic              clr_busy,
    input logic              ovf_clr,
    input logic              unf_clr,
    input logic              ovf_flag,
    input logic              unf_flag,
    input logic [ADDR_W:0]   level,
    input logic              empty,
    input logic              full,
    input logic              empty_evt
);
    localparam int DEPTH = 1 << ADDR_W;

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        level <= (ADDR_W+1)'(DEPTH));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en && !clr_req && !clr_busy) |=> (level == $past(level) && ovf_flag));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !clr_req && !clr_busy) |=> ($stable(rd_data) && unf_flag));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (unf_flag && !unf_clr) |=> unf_flag);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> (level == '0));

    p_evt_single_r5: assert property (@(posedge clk) disable iff (rst)
        empty_evt |=> !empty_evt);

    p_dis_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (in_dis && !rd_en && !clr_req && !clr_busy) |=> (level == $past(level)));
endmodule

bind tsf_fifo_top tsf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .in_dis    (in_dis),
    .clr_req   (clr_req),
    .clr_busy  (clr_busy),
    .ovf_clr   (ovf_clr),
    .unf_clr   (unf_clr),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .level     (level),
    .empty     (empty),
    .full      (full),
    .empty_evt (empty_evt)
);

// File: tb/tsf_fifo_top_tb_top.sv
`timescale 1ns/1ps
module tsf_fifo_top_tb_top;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int FLUSH = 250;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, rd_en = 0, in_dis = 0, clr_req = 0;
    logic          thr_we = 0, ovf_clr = 0, unf_clr = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] thr_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          clr_busy, ovf_flag, unf_flag, empty, full, thr_flag, empty_evt;
    logic [AW-1:0] thr_q;
    logic [AW:0]   level;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    tsf_fifo_top #(.DATA_W(DW), .ADDR_W(AW), .FLUSH_CYC(FLUSH)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .in_dis(in_dis), .clr_req(clr_req), .clr_busy(clr_busy),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_q(thr_q), .ovf_clr(ovf_clr),
        .unf_clr(unf_clr), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .level(level),
        .empty(empty), .full(full), .thr_flag(thr_flag), .empty_evt(empty_evt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en = 1; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic pop(output logic [DW-1:0] d);
        rd_en = 1;
        tick();
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic do_clear();
        clr_req = 1;
        tick();
        clr_req = 0;
        while (clr_busy) tick();
    endtask

    task automatic t_reset();
        chk("R1 level", 32'(level), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 thr", 32'(thr_q), 32'h0000_000E);
        chk("R1 flags", {28'd0, ovf_flag, unf_flag, thr_flag, empty_evt}, 0);
        chk("R1 busy", 32'(clr_busy), 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        logic [DW-1:0] d;
        for (int i = 0; i < 5; i++) push(32'h1100_0000 + 32'(i) * 32'h0101);
        chk("R3 level after 5", 32'(level), 5);
        for (int i = 0; i < 5; i++) begin
            pop(d);
            chk("R2 order", d, 32'h1100_0000 + 32'(i) * 32'h0101);
        end
        chk("R3 level drained", 32'(level), 0);
    endtask

    task automatic t_simul();
        logic [DW-1:0] d;
        push(32'hA0); push(32'hA1);
        wr_en = 1; rd_en = 1; wr_data = 32'hA2;
        tick();
        wr_en = 0; rd_en = 0;
        chk("R3 simultaneous level", 32'(level), 2);
        chk("R2 simultaneous data", rd_data, 32'hA0);
        pop(d); chk("R2 next", d, 32'hA1);
        pop(d); chk("R2 last", d, 32'hA2);
    endtask

    task automatic t_threshold();
        logic [DW-1:0] d;
        for (int i = 0; i < 14; i++) push(32'(i));
        chk("R4 level=thr no flag", 32'(thr_flag), 0);
        push(32'd14);
        chk("R4 level>thr flag", 32'(thr_flag), 1);
        thr_we = 1; thr_wdata = 4'd3;
        tick();
        thr_we = 0;
        chk("R4 thr loaded", 32'(thr_q), 3);
        for (int i = 0; i < 11; i++) pop(d);
        chk("R4 level 4 flag", 32'(thr_flag), 1);
        pop(d);
        chk("R4 level 3 no flag", 32'(thr_flag), 0);
        for (int i = 0; i < 3; i++) pop(d);
        chk("R3 drained", 32'(level), 0);
    endtask

    task automatic t_empty_evt();
        logic [DW-1:0] d;
        thr_we = 1; thr_wdata = '0;
        tick();
        thr_we = 0;
        chk("R5 no evt idle", 32'(empty_evt), 0);
        push(32'h55);
        chk("R4 flag thr0", 32'(thr_flag), 1);
        chk("R5 no evt on fill", 32'(empty_evt), 0);
        pop(d);
        chk("R5 evt pulse", 32'(empty_evt), 1);
        tick();
        chk("R5 evt single", 32'(empty_evt), 0);
    endtask

    task automatic t_overflow();
        logic [DW-1:0] d;
        for (int i = 0; i < DEPTH; i++) push(32'hB000 + 32'(i));
        chk("R6 full", 32'(full), 1);
        chk("R6 no ovf yet", 32'(ovf_flag), 0);
        push(32'hDEAD);
        chk("R6 level kept", 32'(level), DEPTH);
        chk("R6 ovf set", 32'(ovf_flag), 1);
        tick();
        chk("R8 ovf sticky", 32'(ovf_flag), 1);
        ovf_clr = 1; tick(); ovf_clr = 0;
        chk("R8 ovf cleared", 32'(ovf_flag), 0);
        for (int i = 0; i < DEPTH; i++) begin
            pop(d);
            if (i == 0 || i == DEPTH - 1) chk("R6 contents", d, 32'hB000 + 32'(i));
        end
    endtask

    task automatic t_underflow();
        logic [DW-1:0] d;
        pop(d);
        chk("R7 rd_data held", d, 32'hB000 + 32'(DEPTH - 1));
        chk("R7 level", 32'(level), 0);
        chk("R7 unf set", 32'(unf_flag), 1);
        tick();
        chk("R8 unf sticky", 32'(unf_flag), 1);
        unf_clr = 1; tick(); unf_clr = 0;
        chk("R8 unf cleared", 32'(unf_flag), 0);
    endtask

    task automatic t_clear();
        int busy_cycles = 0;
        push(32'hC0); push(32'hC1); push(32'hC2);
        clr_req = 1;
        tick();
        clr_req = 0;
        chk("R9 emptied", 32'(level), 0);
        chk("R9 busy", 32'(clr_busy), 1);
        wr_en = 1; wr_data = 32'hEE;
        tick();
        wr_en = 0;
        busy_cycles = 2;
        chk("R9 write ignored", 32'(level), 0);
        rd_en = 1; tick(); rd_en = 0;
        busy_cycles++;
        chk("R9 read no unf", 32'(unf_flag), 0);
        while (clr_busy && busy_cycles < 1000) begin
            tick();
            busy_cycles++;
        end
        chk("R9 busy length", 32'(busy_cycles - 1), FLUSH);
        chk("R9 busy self-clear", 32'(clr_busy), 0);
    endtask

    task automatic t_disable();
        logic [DW-1:0] d;
        push(32'hD0); push(32'hD1);
        in_dis = 1;
        push(32'hD2); push(32'hD3); push(32'hD4);
        chk("R10 level kept", 32'(level), 2);
        chk("R10 no ovf", 32'(ovf_flag), 0);
        in_dis = 0;
        pop(d); chk("R10 kept 0", d, 32'hD0);
        pop(d); chk("R10 kept 1", d, 32'hD1);
        chk("R10 nothing else", 32'(level), 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_order();
        t_simul();
        t_threshold();
        t_empty_evt();
        t_overflow();
        t_underflow();
        t_clear();
        t_disable();
        do_clear();
        done = 1;
        summary();
    end
endmodule